// File: doc/BRIEF.md
# Periodic DRAM Refresh Engine

This block keeps an external DRAM alive. A free-running divide-by-32 prescaler clocks an 8-bit down-counter. The counter reloads from a programmable value each time it wraps, and every time it reaches zero the block raises a refresh request toward the system bus arbiter. Once the arbiter grants the bus, the block drives a CAS-before-RAS refresh cycle on its active-low strobe outputs and then releases the request.

The block also covers the low-power stop mode. While stop is asserted, the interval counter freezes and no arbitrated refresh cycle is started. If the self-refresh select bit is set when stop begins, the block lowers CAS and then RAS and holds both low for the whole of stop. On wake-up it raises both strobes in the same cycle and waits out a fixed precharge interval before it serves requests again. The control register carries the timer run bit at position 7 and the self-refresh select bit at position 4. The remaining bits are ignored.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: During and right after reset, arb_req is 0 and ras_n and cas_n are both 1.
- R2: The interval counter and prescaler stay idle and no request appears until control bit 7 is written as 1. Writing bit 7 as 0 stops them and clears the prescaler.
- R3: With reload value n (1 to 255) and the bus always granted, successive rising edges of arb_req are exactly (n+1)*32 clock cycles apart.
- R4: A reload write loads both the reload value and the live count. With n loaded before the run bit is set, the first request rises 32*n+1 cycles after the clock edge that captures the run bit. A reload value of 0 produces no requests.
- R5: An ungranted request keeps arb_req at 1, and any further expiries merge into it, so a single grant yields exactly one refresh cycle.
- R6: No strobe moves until arb_grant is seen with arb_req at 1. In each refresh cycle cas_n falls CAS_LEAD cycles before ras_n, ras_n stays low for RAS_CYC cycles, and ras_n and cas_n rise in the same cycle.
- R7: While stop_mode is 1 and self-refresh is not selected, the counter holds its value, arb_req is 0 and both strobes stay high. The next request is delayed by exactly the number of stopped cycles.
- R8: If control bit 4 is 1 when stop_mode rises, cas_n falls before ras_n, and both stay low for as long as stop_mode stays 1.
- R9: When stop_mode falls after self-refresh, ras_n and cas_n rise together, and arb_req stays 0 for EXIT_CYC cycles. A request that is pending and granted starts its CAS edge EXIT_CYC+1 cycles after the strobes rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control data: bit 7 runs the timer, bit 4 selects self-refresh |
| reload_wr | input | 1 | Write strobe for the interval reload value |
| reload_wdata | input | TMR_W | Reload value n; also loaded into the live count |
| stop_mode | input | 1 | Low-power stop indication |
| arb_grant | input | 1 | Bus grant from the arbiter |
| arb_req | output | 1 | Refresh request; held through the refresh cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |

## Verification
The interval is swept over reload values 1 to 8 and then 15, 128 and 255. The spacing between requests separates an off-by-one in the wrap or reload from an error in the prescaler division, and the delay to the first request separates the load path from the reload path. Withholding the grant across many expiries shows whether requests merge or pile up. Stop is tried with self-refresh off and on. This separates a frozen counter from one that keeps counting, and it checks the strobe order at entry, the release on wake-up and the precharge gap.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  // Control register field positions decoded by the top level
  localparam int CTRL_RUN_BIT  = 7;
  localparam int CTRL_SELF_BIT = 4;

  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_CAS      = 3'd1,
    S_RAS      = 3'd2,
    S_REL      = 3'd3,
    S_SELF_CAS = 3'd4,
    S_SELF     = 3'd5,
    S_EXIT     = 3'd6
  } rfsh_state_e;

endpackage

// File: rtl/rfsh_prescaler.sv
module rfsh_prescaler #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  assign tick = en && (pre_q == LAST);

  always_comb begin
    pre_d = pre_q;
    if (clear)     pre_d = '0;
    else if (tick) pre_d = '0;
    else if (en)   pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R3: a tick is a single-cycle event separated by DIV cycles
  a_r3_tick_single : assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R2: a cleared prescaler never ticks
  a_r2_clear_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !tick);

endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [TMR_W-1:0] count_q, count_d;
  logic [TMR_W-1:0] reload_q, reload_d;
  logic             expire_q, expire_d;

  always_comb begin
    count_d  = count_q;
    reload_d = reload_q;
    expire_d = 1'b0;
    if (load) begin
      count_d  = load_val;
      reload_d = load_val;
    end else if (tick) begin
      if (count_q == '0) begin
        count_d = reload_q;
      end else begin
        count_d  = count_q - TMR_W'(1);
        expire_d = (count_q == TMR_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      expire_q <= 1'b0;
    end else begin
      count_q  <= count_d;
      reload_q <= reload_d;
      expire_q <= expire_d;
    end
  end

  assign expire = expire_q;

  // R4: a wrap restores the stored reload value
  a_r4_wrap_reload : assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && count_q == '0) |=> (count_q == $past(reload_q)));

  // R7: without a tick or a load the count is frozen
  a_r7_count_frozen : assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count_q));

  // R4: an expiry always leaves the counter at zero
  a_r4_expire_at_zero : assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> (count_q == '0));

endmodule

// File: rtl/rfsh_sequencer.sv
module rfsh_sequencer
  import dram_rfsh_pkg::*;
#(
  parameter int CAS_LEAD = 1,
  parameter int RAS_CYC  = 4,
  parameter int PRE_CYC  = 2,
  parameter int EXIT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic stop_mode,
  input  logic self_sel,
  input  logic arb_grant,
  output logic arb_req,
  output logic ras_n,
  output logic cas_n
);
  localparam int CNT_W = $clog2(CAS_LEAD + RAS_CYC + PRE_CYC + EXIT_CYC + 1);
  localparam logic [CNT_W-1:0] LD_CAS  = CNT_W'(CAS_LEAD - 1);
  localparam logic [CNT_W-1:0] LD_RAS  = CNT_W'(RAS_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PRE  = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_EXIT = CNT_W'(EXIT_CYC - 1);

  rfsh_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             ras_q, ras_d;
  logic             cas_q, cas_d;
  logic             accept;
  logic             cnt_done;

  assign cnt_done = (cnt_q == '0);
  assign accept   = (state_q == S_IDLE) && !stop_mode && pend_q && arb_grant;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_done ? cnt_q : cnt_q - CNT_W'(1);
    pend_d  = expire ? 1'b1 : (accept ? 1'b0 : pend_q);
    unique case (state_q)
      S_IDLE: begin
        cnt_d = cnt_q;
        if (stop_mode) begin
          if (self_sel) begin
            state_d = S_SELF_CAS;
            cnt_d   = LD_CAS;
          end
        end else if (accept) begin
          state_d = S_CAS;
          cnt_d   = LD_CAS;
        end
      end
      S_CAS: if (cnt_done) begin
        state_d = S_RAS;
        cnt_d   = LD_RAS;
      end
      S_RAS: if (cnt_done) begin
        state_d = S_REL;
        cnt_d   = LD_PRE;
      end
      S_REL: if (cnt_done) state_d = S_IDLE;
      S_SELF_CAS: if (cnt_done) state_d = S_SELF;
      S_SELF: begin
        cnt_d = cnt_q;
        if (!stop_mode) begin
          state_d = S_EXIT;
          cnt_d   = LD_EXIT;
        end
      end
      S_EXIT: if (cnt_done) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    ras_d = !(state_d inside {S_RAS, S_SELF});
    cas_d = !(state_d inside {S_CAS, S_RAS, S_SELF_CAS, S_SELF});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      ras_q   <= ras_d;
      cas_q   <= cas_d;
    end
  end

  assign ras_n   = ras_q;
  assign cas_n   = cas_q;
  assign arb_req = ((state_q == S_IDLE) && pend_q && !stop_mode) ||
                   (state_q inside {S_CAS, S_RAS, S_REL});

  // R6: row strobe only falls while the column strobe is already low
  a_r6_cas_first : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(cas_n) == 1'b0));

  // R6, R9: both strobes are released in the same cycle
  a_r6_release_together : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);

  // R6: a normal refresh cycle starts only on a grant
  a_r6_grant_needed : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CAS && $past(state_q) == S_IDLE) |-> $past(arb_grant));

  // R7: no arbitrated refresh is started while stopped
  a_r7_no_cbr_stopped : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && stop_mode) |=> (state_q != S_CAS));

  // R8: self-refresh is held while stop remains
  a_r8_self_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SELF && stop_mode) |=> (state_q == S_SELF && !ras_n && !cas_n));

  // R9: the precharge gap after wake-up keeps the bus quiet
  a_r9_exit_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_EXIT) |-> (!arb_req && ras_n && cas_n));

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dram_rfsh_pkg::*;
#(
  parameter int TMR_W    = 8,
  parameter int DIV      = 32,
  parameter int CAS_LEAD = 1,
  parameter int RAS_CYC  = 4,
  parameter int PRE_CYC  = 2,
  parameter int EXIT_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [7:0]       ctrl_wdata,
  input  logic             reload_wr,
  input  logic [TMR_W-1:0] reload_wdata,
  input  logic             stop_mode,
  input  logic             arb_grant,
  output logic             arb_req,
  output logic             ras_n,
  output logic             cas_n
);
  logic run_q, run_d;
  logic self_q, self_d;
  logic tmr_en;
  logic tick;
  logic expire;

  always_comb begin
    run_d  = run_q;
    self_d = self_q;
    if (ctrl_wr) begin
      run_d  = ctrl_wdata[CTRL_RUN_BIT];
      self_d = ctrl_wdata[CTRL_SELF_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      self_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      self_q <= self_d;
    end
  end

  assign tmr_en = run_q && !stop_mode;

  rfsh_prescaler #(.DIV(DIV)) u_prescaler (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!run_q),
    .en    (tmr_en),
    .tick  (tick)
  );

  rfsh_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reload_wr),
    .load_val (reload_wdata),
    .tick     (tick),
    .expire   (expire)
  );

  rfsh_sequencer #(
    .CAS_LEAD (CAS_LEAD),
    .RAS_CYC  (RAS_CYC),
    .PRE_CYC  (PRE_CYC),
    .EXIT_CYC (EXIT_CYC)
  ) u_sequencer (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .stop_mode (stop_mode),
    .self_sel  (self_q),
    .arb_grant (arb_grant),
    .arb_req   (arb_req),
    .ras_n     (ras_n),
    .cas_n     (cas_n)
  );

  // R2, R7: the interval logic only advances while running and not stopped
  a_r2_no_tick_idle : assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q || stop_mode) |-> !tick);

  // R1: strobes are idle in the first cycle after reset
  a_r1_reset_idle : assert property (@(posedge clk)
    !rst_n |=> (ras_n && cas_n));

endmodule

// File: tb/dram_refresh_ctrl_bench.sv
module dram_refresh_ctrl_bench;
  localparam int TMR_W    = 8;
  localparam int DIV      = 32;
  localparam int CAS_LEAD = 1;
  localparam int RAS_CYC  = 4;
  localparam int PRE_CYC  = 2;
  localparam int EXIT_CYC = 8;

  logic             clk;
  logic             rst_n;
  logic             ctrl_wr;
  logic [7:0]       ctrl_wdata;
  logic             reload_wr;
  logic [TMR_W-1:0] reload_wdata;
  logic             stop_mode;
  logic             arb_grant;
  logic             arb_req;
  logic             ras_n;
  logic             cas_n;

  int checks;
  int fails;
  int cyc;
  bit done;

  int rise_cnt, last_rise;
  int cas_falls, last_cas_fall;
  int ras_rises, last_ras_rise;
  int ras_low_len;
  bit in_self;
  logic prev_req, prev_ras, prev_cas;

  dram_refresh_ctrl #(
    .TMR_W(TMR_W), .DIV(DIV), .CAS_LEAD(CAS_LEAD),
    .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC), .EXIT_CYC(EXIT_CYC)
  ) u_dram_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .reload_wr(reload_wr), .reload_wdata(reload_wdata), .stop_mode(stop_mode),
    .arb_grant(arb_grant), .arb_req(arb_req), .ras_n(ras_n), .cas_n(cas_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Strobe and request monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (arb_req && !prev_req) begin
        rise_cnt++;
        last_rise = cyc;
      end
      if (!cas_n && prev_cas) begin
        cas_falls++;
        last_cas_fall = cyc;
      end
      if (!ras_n && prev_ras)
        chk(prev_cas == 1'b0, "R6 cas low before ras falls", int'(prev_cas), 0);
      if (!ras_n) ras_low_len++;
      if (ras_n && !prev_ras) begin
        ras_rises++;
        last_ras_rise = cyc;
        chk(cas_n == 1'b1, "R6 cas rises with ras", int'(cas_n), 1);
        if (!in_self)
          chk(ras_low_len == RAS_CYC, "R6 ras low width", ras_low_len, RAS_CYC);
        ras_low_len = 0;
      end
    end
    prev_req = arb_req;
    prev_ras = ras_n;
    prev_cas = cas_n;
  end

  task automatic wr_ctrl(input logic [7:0] d, output int cap);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    cap = cyc;
    ctrl_wr = 1'b0;
  endtask

  task automatic wr_reload(input logic [TMR_W-1:0] d);
    @(negedge clk);
    reload_wr = 1'b1; reload_wdata = d;
    @(negedge clk);
    reload_wr = 1'b0;
  endtask

  task automatic wait_rise(output int t);
    int target;
    target = rise_cnt + 1;
    while (rise_cnt < target) @(posedge clk);
    t = last_rise;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int cap, t1, t2, t3, r0, c0;
    checks = 0; fails = 0; cyc = 0; done = 0;
    rise_cnt = 0; cas_falls = 0; ras_rises = 0; ras_low_len = 0; in_self = 0;
    last_rise = 0; last_cas_fall = 0; last_ras_rise = 0;
    prev_req = 0; prev_ras = 1; prev_cas = 1;
    rst_n = 0; ctrl_wr = 0; ctrl_wdata = '0; reload_wr = 0; reload_wdata = '0;
    stop_mode = 0; arb_grant = 0;

    repeat (3) @(negedge clk);
    chk(arb_req == 0 && ras_n && cas_n, "R1 outputs in reset",
        {arb_req, ras_n, cas_n}, 3'b011);
    rst_n = 1;
    @(negedge clk);
    chk(arb_req == 0 && ras_n && cas_n, "R1 outputs after reset",
        {arb_req, ras_n, cas_n}, 3'b011);

    // R2: loaded but not running -> nothing
    arb_grant = 1;
    wr_reload(8'd1);
    idle(1000);
    chk(rise_cnt == 0, "R2 no request before run bit", rise_cnt, 0);

    // R3/R4 sweep of reload values
    for (int i = 0; i < 11; i++) begin
      int n;
      n = (i < 8) ? i + 1 : (i == 8 ? 15 : (i == 9 ? 128 : 255));
      wr_ctrl(8'h00, cap);
      wr_reload(TMR_W'(n));
      wr_ctrl(8'h80, cap);
      wait_rise(t1);
      chk(t1 - cap == 32 * n + 1, "R4 first request delay", t1 - cap, 32 * n + 1);
      wait_rise(t2);
      wait_rise(t3);
      chk(t3 - t2 == (n + 1) * DIV, "R3 request period", t3 - t2, (n + 1) * DIV);
      chk(t2 - t1 == (n + 1) * DIV, "R3 request period", t2 - t1, (n + 1) * DIV);
    end

    // R2: clearing the run bit stops requests
    wr_ctrl(8'h00, cap);
    r0 = rise_cnt;
    idle(600);
    chk(rise_cnt == r0, "R2 run bit cleared stops requests", rise_cnt, r0);

    // R4: reload of zero never requests
    wr_reload(8'd0);
    wr_ctrl(8'h80, cap);
    idle(2000);
    chk(rise_cnt == r0, "R4 zero reload gives no request", rise_cnt, r0);

    // R7: stop without self-refresh freezes the interval
    wr_ctrl(8'h00, cap);
    wr_reload(8'd3);
    wr_ctrl(8'h80, cap);
    wait_rise(t1);
    wait_rise(t1);
    idle(40);
    c0 = cas_falls;
    stop_mode = 1;
    idle(500);
    chk(arb_req == 0 && ras_n && cas_n, "R7 quiet outputs during stop",
        {arb_req, ras_n, cas_n}, 3'b011);
    chk(cas_falls == c0, "R7 no refresh cycle in stop", cas_falls, c0);
    stop_mode = 0;
    wait_rise(t2);
    chk(t2 - t1 == 4 * DIV + 500, "R7 interval shifted by stop", t2 - t1, 4 * DIV + 500);

    // R5/R6: withheld grant, many expiries, one cycle
    wr_ctrl(8'h00, cap);
    wr_reload(8'd1);
    arb_grant = 0;
    r0 = rise_cnt;
    c0 = cas_falls;
    wr_ctrl(8'h80, cap);
    idle(400);
    chk(arb_req == 1, "R5 request held without grant", arb_req, 1);
    chk(rise_cnt == r0 + 1, "R5 expiries merged", rise_cnt, r0 + 1);
    chk(cas_falls == c0, "R6 no strobe before grant", cas_falls, c0);
    wr_ctrl(8'h00, cap);
    arb_grant = 1;
    idle(40);
    chk(cas_falls == c0 + 1, "R5 one cycle per grant", cas_falls, c0 + 1);
    chk(arb_req == 0, "R5 request dropped after cycle", arb_req, 0);

    // R8/R9: self-refresh through stop
    arb_grant = 0;
    wr_reload(8'd3);
    wr_ctrl(8'h90, cap);
    wait_rise(t1);
    in_self = 1;
    c0 = ras_rises;
    stop_mode = 1;
    idle(300);
    chk(!ras_n && !cas_n, "R8 strobes held low in stop", {ras_n, cas_n}, 0);
    chk(arb_req == 0, "R8 no request in self-refresh", arb_req, 0);
    idle(200);
    chk(!ras_n && !cas_n, "R8 strobes still low", {ras_n, cas_n}, 0);
    arb_grant = 1;
    stop_mode = 0;
    while (ras_rises == c0) @(posedge clk);
    in_self = 0;
    @(negedge clk);
    chk(arb_req == 0, "R9 no request during precharge", arb_req, 0);
    c0 = cas_falls;
    while (cas_falls == c0) @(posedge clk);
    chk(last_cas_fall - last_ras_rise == EXIT_CYC + 1, "R9 precharge gap",
        last_cas_fall - last_ras_rise, EXIT_CYC + 1);
    idle(20);

    done = 1;
    summary();
    $finish;
  end

endmodule